// File: doc/BRIEF.md
# Power Mode and Wake Controller

This block decides which clocks of a dual-clock microcontroller run. It holds the device in one of four operating states: two run states and two low-power states. The run states are full-speed, clocked from the fast internal RC oscillator, and reduced-speed, clocked from the 32 kHz internal RC oscillator. The low-power states are standby and halt. Software moves the device between states with a one-cycle mode command. Interrupt activity brings it out of a low-power state.

In standby the core clock stops, but the peripheral clock keeps running from the oscillator that fed the run state just left. Timer and detector interrupts therefore still work and can wake the device. Halt stops both oscillator enables. Only the sources that can fire without a system clock may then wake the device. A wake event returns the device to the run state chosen by a selector input and sends a one-cycle pulse to the core. On entry to full speed after the fast oscillator has been off, the core and peripheral clocks are held off for a settle count.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode code is 00 (normal). The fast source enable, core clock enable and peripheral clock enable are 1. The slow source enable and the wake pulse are 0.
- R2: The mode code is 00 normal, 01 slow, 10 standby, 11 halt. When the core clock enable is 1 and `cmd_valid` is high, a `cmd_mode` that differs from the current mode becomes the mode code on the next clock edge.
- R3: In normal, the fast source enable is 1 and the slow one is 0. In slow, the slow source enable, core clock enable and peripheral clock enable are 1 and the fast one is 0.
- R4: In standby, the core clock enable is 0 and the peripheral clock enable is 1. The source enable of the run mode that was left stays on: fast if standby was entered from normal, slow if it was entered from slow.
- R5: In halt, all four clock enables are 0.
- R6: In standby, any request bit whose enable bit is set wakes the device at the next edge. Bit 0 is Timer0 overflow, bit 1 Timer1 borrow, bit 2 watchdog, bit 3 port change, bit 4 external interrupt, bit 5 low-voltage detect, bit 6 touch comparator, bit 7 touch counter overflow.
- R7: In halt, only bits 2, 3, 4, 6 and 7 wake the device. Requests on bits 0, 1 and 5 leave the mode at 11.
- R8: A request whose enable bit is 0 never wakes the device.
- R9: A wake moves the mode to 00 when `wake_target` is 0 and to 01 when it is 1. `wake_pulse` is high for exactly the one cycle in which the new run mode first shows.
- R10: On entry to normal from slow, from halt, or from a standby entered from slow, core and peripheral clock enables stay 0 for the first 16 cycles in mode 00 and turn on in the 17th. A wake from a standby entered from normal turns the core on at once.
- R11: Mode commands are ignored while the core clock enable is 0: in standby, in halt, and during the settle count.
- R12: `wake_pulse` stays 0 in the run modes, even with enabled requests present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Software mode command strobe |
| cmd_mode | input | 2 | Requested mode code |
| wake_target | input | 1 | Run mode after wake: 0 normal, 1 slow |
| irq_req | input | NUM_SRC | Interrupt request lines |
| irq_en | input | NUM_SRC | Interrupt enable bits |
| hs_clk_en | output | 1 | Fast oscillator enable |
| ls_clk_en | output | 1 | Slow oscillator enable |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| mode_o | output | 2 | Current mode code |
| wake_pulse | output | 1 | One-cycle wake indication to the core |

## Verification
The bench gives each of the eight sources its own turn at waking standby. A filter with the wrong index or mask would leave the mode stuck at 10. It drives the three timer and detector sources in halt, where a design that used the standby mask would wake when it should stay at 11. It counts the settle window cycle by cycle from both a slow entry and a halt wake, so an off-by-one counter or a skipped settle shows as an early core enable. It also issues commands during standby and during settling, where a design that obeyed them would change the mode code.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

   typedef enum logic [1:0] {
      MODE_NORMAL  = 2'b00,
      MODE_SLOW    = 2'b01,
      MODE_STANDBY = 2'b10,
      MODE_HALT    = 2'b11
   } pwr_mode_e;

   localparam int unsigned WAKE_SRC_MAX = 32;

   function automatic logic is_low_power(input pwr_mode_e m);
      return (m == MODE_STANDBY) || (m == MODE_HALT);
   endfunction

endpackage

// File: rtl/pwr_wake_filter.sv
module pwr_wake_filter
   import pwr_mode_pkg::*;
#(
   parameter int unsigned          NUM_SRC        = 8,
   parameter logic [NUM_SRC-1:0]   HALT_WAKE_MASK = '1
) (
   input  pwr_mode_e            mode_i,
   input  logic [NUM_SRC-1:0]   irq_req_i,
   input  logic [NUM_SRC-1:0]   irq_en_i,
   output logic                 wake_o
);

   logic              in_standby;
   logic              in_halt;
   logic [NUM_SRC-1:0] armed;

   assign in_standby = (mode_i == MODE_STANDBY);
   assign in_halt    = (mode_i == MODE_HALT);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (HALT_WAKE_MASK[i]) begin : g_halt_ok
         assign armed[i] = irq_req_i[i] & irq_en_i[i] & (in_standby | in_halt);
      end else begin : g_standby_only
         assign armed[i] = irq_req_i[i] & irq_en_i[i] & in_standby;
      end
   end

   assign wake_o = |armed;

endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
   parameter int unsigned SETTLE_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic done_o
);

   if (SETTLE_CYC == 0) begin : g_none
      logic unused_inputs;
      assign unused_inputs = start_i ^ clk ^ rst_n;
      assign done_o        = 1'b1;
   end else begin : g_cnt
      localparam int unsigned CW = $clog2(SETTLE_CYC + 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               cnt_q <= '0;
         else if (start_i)         cnt_q <= CW'(SETTLE_CYC);
         else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
      end

      assign done_o = (cnt_q == '0);

      // R10: a fresh settle window never reports done on the next cycle
      assert_settle_restart_R10: assert property (
         @(posedge clk) disable iff (!rst_n) start_i |=> !done_o);
   end

endmodule

// File: rtl/pwr_clk_map.sv
module pwr_clk_map
   import pwr_mode_pkg::*;
(
   input  pwr_mode_e mode_i,
   input  logic      sby_ls_i,
   input  logic      settled_i,
   output logic      hs_en_o,
   output logic      ls_en_o,
   output logic      core_en_o,
   output logic      periph_en_o
);

   always_comb begin
      hs_en_o     = 1'b0;
      ls_en_o     = 1'b0;
      core_en_o   = 1'b0;
      periph_en_o = 1'b0;
      unique case (mode_i)
         MODE_NORMAL: begin
            hs_en_o     = 1'b1;
            core_en_o   = settled_i;
            periph_en_o = settled_i;
         end
         MODE_SLOW: begin
            ls_en_o     = 1'b1;
            core_en_o   = 1'b1;
            periph_en_o = 1'b1;
         end
         MODE_STANDBY: begin
            hs_en_o     = !sby_ls_i;
            ls_en_o     = sby_ls_i;
            periph_en_o = 1'b1;
         end
         MODE_HALT: begin
         end
         default: begin
         end
      endcase
   end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pwr_mode_pkg::*;
#(
   parameter int unsigned        NUM_SRC        = 8,
   parameter logic [NUM_SRC-1:0] HALT_WAKE_MASK = 8'hDC,
   parameter int unsigned        SETTLE_CYC     = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [1:0]         cmd_mode,
   input  logic               wake_target,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic [NUM_SRC-1:0] irq_en,
   output logic               hs_clk_en,
   output logic               ls_clk_en,
   output logic               core_clk_en,
   output logic               periph_clk_en,
   output logic [1:0]         mode_o,
   output logic               wake_pulse
);

   initial begin
      assert (NUM_SRC >= 1 && NUM_SRC <= WAKE_SRC_MAX)
         else $error("pwr_mode_ctrl: NUM_SRC out of range");
      assert (SETTLE_CYC < 65536)
         else $error("pwr_mode_ctrl: SETTLE_CYC too large");
   end

   pwr_mode_e mode_q, mode_d;
   logic      sby_ls_q, sby_ls_d;
   logic      wake_q, wake_d;
   logic      wake_hit;
   logic      settled;
   logic      settle_start;
   logic      hs_was_on;
   pwr_mode_e req_mode;

   assign req_mode = pwr_mode_e'(cmd_mode);

   pwr_wake_filter #(
      .NUM_SRC        (NUM_SRC),
      .HALT_WAKE_MASK (HALT_WAKE_MASK)
   ) u_filter (
      .mode_i    (mode_q),
      .irq_req_i (irq_req),
      .irq_en_i  (irq_en),
      .wake_o    (wake_hit)
   );

   pwr_settle_timer #(
      .SETTLE_CYC (SETTLE_CYC)
   ) u_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (settle_start),
      .done_o  (settled)
   );

   pwr_clk_map u_map (
      .mode_i      (mode_q),
      .sby_ls_i    (sby_ls_q),
      .settled_i   (settled),
      .hs_en_o     (hs_clk_en),
      .ls_en_o     (ls_clk_en),
      .core_en_o   (core_clk_en),
      .periph_en_o (periph_clk_en)
   );

   always_comb begin
      mode_d   = mode_q;
      sby_ls_d = sby_ls_q;
      wake_d   = 1'b0;
      if (is_low_power(mode_q) && wake_hit) begin
         mode_d = wake_target ? MODE_SLOW : MODE_NORMAL;
         wake_d = 1'b1;
      end else if (core_clk_en && cmd_valid && (req_mode != mode_q)) begin
         mode_d = req_mode;
         if (req_mode == MODE_STANDBY) sby_ls_d = (mode_q == MODE_SLOW);
      end
   end

   assign hs_was_on    = (mode_q == MODE_NORMAL) ||
                         ((mode_q == MODE_STANDBY) && !sby_ls_q);
   assign settle_start = (mode_d == MODE_NORMAL) && !hs_was_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_NORMAL;
         sby_ls_q <= 1'b0;
         wake_q   <= 1'b0;
      end else begin
         mode_q   <= mode_d;
         sby_ls_q <= sby_ls_d;
         wake_q   <= wake_d;
      end
   end

   assign mode_o     = mode_q;
   assign wake_pulse = wake_q;

   assert_halt_all_off_R5: assert property (
      @(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_HALT) |-> (!hs_clk_en && !ls_clk_en && !periph_clk_en && !core_clk_en));

   assert_core_stopped_R4: assert property (
      @(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_STANDBY) |-> (!core_clk_en && periph_clk_en && (hs_clk_en != ls_clk_en)));

   assert_standby_wakes_R6: assert property (
      @(posedge clk) disable iff (!rst_n)
      ((mode_q == MODE_STANDBY) && ((irq_req & irq_en) != '0)) |=> wake_q);

   assert_halt_masked_R7: assert property (
      @(posedge clk) disable iff (!rst_n)
      ((mode_q == MODE_HALT) && ((irq_req & irq_en & HALT_WAKE_MASK) == '0)) |=> (mode_q == MODE_HALT));

   assert_wake_single_R9: assert property (
      @(posedge clk) disable iff (!rst_n) wake_q |=> !wake_q);

   assert_cmd_ignored_R11: assert property (
      @(posedge clk) disable iff (!rst_n)
      (!core_clk_en && !(is_low_power(mode_q) && wake_hit)) |=> $stable(mode_q));

   assert_no_pulse_run_R12: assert property (
      @(posedge clk) disable iff (!rst_n)
      !is_low_power(mode_q) |=> !wake_q);

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_mode = 2'b00;
   logic       wake_target = 1'b0;
   logic [7:0] irq_req = '0;
   logic [7:0] irq_en = '0;
   logic       hs_clk_en, ls_clk_en, core_clk_en, periph_clk_en, wake_pulse;
   logic [1:0] mode_o;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   pwr_mode_ctrl u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_valid     (cmd_valid),
      .cmd_mode      (cmd_mode),
      .wake_target   (wake_target),
      .irq_req       (irq_req),
      .irq_en        (irq_en),
      .hs_clk_en     (hs_clk_en),
      .ls_clk_en     (ls_clk_en),
      .core_clk_en   (core_clk_en),
      .periph_clk_en (periph_clk_en),
      .mode_o        (mode_o),
      .wake_pulse    (wake_pulse)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cmd(input logic [1:0] m);
      cmd_valid = 1'b1;
      cmd_mode  = m;
      tick();
      cmd_valid = 1'b0;
   endtask

   task automatic t_reset();
      check("R1", "mode", mode_o, 0);
      check("R1", "hs", hs_clk_en, 1);
      check("R1", "ls", ls_clk_en, 0);
      check("R1", "core", core_clk_en, 1);
      check("R1", "periph", periph_clk_en, 1);
      check("R1", "wake", wake_pulse, 0);
   endtask

   task automatic t_run_modes();
      cmd(2'b01);
      check("R2", "mode slow", mode_o, 1);
      check("R3", "slow hs", hs_clk_en, 0);
      check("R3", "slow ls", ls_clk_en, 1);
      check("R3", "slow core", core_clk_en, 1);
      cmd(2'b00);
      check("R2", "mode normal", mode_o, 0);
      check("R3", "normal hs", hs_clk_en, 1);
      check("R3", "normal ls", ls_clk_en, 0);
      check("R10", "settle core", core_clk_en, 0);
      check("R10", "settle periph", periph_clk_en, 0);
      cmd(2'b01);
      check("R11", "cmd during settle", mode_o, 0);
      repeat (14) tick();
      check("R10", "core at 16th", core_clk_en, 0);
      tick();
      check("R10", "core at 17th", core_clk_en, 1);
      check("R10", "periph at 17th", periph_clk_en, 1);
   endtask

   task automatic t_standby_all();
      for (int s = 0; s < 8; s++) begin
         cmd(2'b10);
         check("R4", "standby mode", mode_o, 2);
         check("R4", "standby core", core_clk_en, 0);
         check("R4", "standby periph", periph_clk_en, 1);
         check("R4", "standby hs kept", hs_clk_en, 1);
         wake_target = 1'b0;
         irq_en  = 8'(1 << s);
         irq_req = 8'(1 << s);
         tick();
         check("R6", $sformatf("wake src %0d", s), mode_o, 0);
         check("R9", "pulse high", wake_pulse, 1);
         check("R10", "no settle from fast standby", core_clk_en, 1);
         irq_req = '0;
         irq_en  = '0;
         tick();
         check("R9", "pulse single", wake_pulse, 0);
      end
   endtask

   task automatic t_standby_slow();
      cmd(2'b01);
      cmd(2'b10);
      check("R4", "standby from slow ls", ls_clk_en, 1);
      check("R4", "standby from slow hs", hs_clk_en, 0);
      cmd(2'b01);
      check("R11", "cmd in standby", mode_o, 2);
      wake_target = 1'b1;
      irq_en  = 8'h20;
      irq_req = 8'h20;
      tick();
      check("R9", "wake to slow", mode_o, 1);
      check("R9", "slow core", core_clk_en, 1);
      irq_req = '0;
      irq_en  = '0;
   endtask

   task automatic t_halt_slow();
      cmd(2'b11);
      check("R5", "halt mode", mode_o, 3);
      check("R5", "halt hs", hs_clk_en, 0);
      check("R5", "halt ls", ls_clk_en, 0);
      check("R5", "halt core", core_clk_en, 0);
      check("R5", "halt periph", periph_clk_en, 0);
      wake_target = 1'b1;
      irq_en  = 8'h80;
      irq_req = 8'h80;
      tick();
      check("R7", "touch ovf wakes halt", mode_o, 1);
      check("R9", "halt pulse", wake_pulse, 1);
      irq_req = '0;
      irq_en  = '0;
      cmd(2'b00);
      repeat (16) tick();
   endtask

   task automatic t_halt_blocked();
      cmd(2'b11);
      wake_target = 1'b0;
      irq_en  = 8'hFF;
      irq_req = 8'h23;
      repeat (3) tick();
      check("R7", "timers/lvd ignored", mode_o, 3);
      check("R7", "no pulse", wake_pulse, 0);
      cmd(2'b01);
      check("R11", "cmd in halt", mode_o, 3);
      irq_req = 8'h04;
      irq_en  = 8'hFB;
      repeat (2) tick();
      check("R8", "disabled wdt", mode_o, 3);
      irq_en = 8'hFF;
      tick();
      check("R9", "wake to normal", mode_o, 0);
      check("R10", "halt wake settles", core_clk_en, 0);
      irq_req = '0;
      repeat (15) tick();
      check("R10", "still settling", core_clk_en, 0);
      tick();
      check("R10", "settled", core_clk_en, 1);
   endtask

   task automatic t_no_pulse_run();
      irq_en  = 8'hFF;
      irq_req = 8'hFF;
      repeat (3) tick();
      check("R12", "no pulse normal", wake_pulse, 0);
      check("R12", "mode normal", mode_o, 0);
      irq_req = '0;
      irq_en  = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #22;
      rst_n = 1'b1;
      #1;
      t_reset();
      tick();
      t_run_modes();
      t_standby_all();
      t_standby_slow();
      t_halt_slow();
      t_halt_blocked();
      t_no_pulse_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule